// File: doc/BRIEF.md
# Receive Holding Queue

This block sits between a serial deserializer and the bus read path of a UART. It holds up to four received bytes in arrival order, shows the oldest byte on a read data output, and removes that byte when the processor reads the receive buffer. It produces two status flags: a data-available flag and a queue-full flag. It also gives the deserializer a combinational accept signal that says whether a new byte may be delivered.

A line break event is also queued, as a zero byte. It raises a sticky break flag. When the queue is already full, the zero byte takes the place of the newest stored byte, so the break is never lost. A receiver-reset command empties the queue at once.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the queue is empty, `data_avail` and `q_full` are 0, `rd_data` is 0 and `brk_flag` is 0.
- R2: `data_avail` is 1 whenever at least one byte is stored. It returns to 0 on the edge where a read removes the last byte.
- R3: `q_full` is 1 exactly when four bytes are stored. Any read that removes a byte clears it.
- R4: `rd_data` shows the oldest stored byte. A read (`rd_pop` high at a clock edge) removes that byte, and the next-oldest byte becomes visible.
- R5: `rx_accept` equals `rx_en` AND NOT `q_full`, combinationally. A byte on `rx_valid`/`rx_byte` is stored only when `rx_accept` is 1. Otherwise it is ignored.
- R6: A `brk_evt` pulse queues a byte of value 0x00 whatever the value of `rx_en`, and sets `brk_flag`. `brk_clr` clears `brk_flag`. When both arrive in the same cycle, the set wins.
- R7: A `brk_evt` while four bytes are stored replaces the newest byte with 0x00. The older three bytes and `q_full` are unchanged.
- R8: `rx_flush` empties the queue on the next edge and clears `data_avail` and `q_full`. It takes priority over any push or break in the same cycle, and it does not change `brk_flag`.
- R9: A read while the queue is empty sees `rd_data` = 0 and changes no state.
- R10: A push and a read in the same cycle leave the occupancy unchanged. The pushed byte lands behind the remaining older bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| rx_flush | input | 1 | Receiver-reset command pulse |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_byte | input | W | Byte from deserializer |
| brk_evt | input | 1 | Line break detected pulse |
| brk_clr | input | 1 | Clear the break flag |
| rd_pop | input | 1 | Receive-buffer read strobe |
| rd_data | output | W | Oldest stored byte, 0 when empty |
| data_avail | output | 1 | At least one byte stored |
| q_full | output | 1 | Four bytes stored |
| rx_accept | output | 1 | Deserializer may deliver a byte |
| brk_flag | output | 1 | Sticky break flag |

## Verification
A wrong occupancy count shows at the ports within one edge. The flags go wrong, or `rd_data` exposes a stale or missing byte. `rx_accept` changes in the same cycle as a wrong `q_full`. A slip in shifting or write position shows only when the affected entry reaches the head, up to three reads later. For that reason every scenario drains the queue completely and compares each byte in order. Break overwrite and same-cycle push-with-read are checked the same way, through the full read-out order.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         rx_flush,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         brk_evt,
  input  logic         brk_clr,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         data_avail,
  output logic         q_full,
  output logic         rx_accept,
  output logic         brk_flag
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem     [DEPTH];
  logic [W-1:0]  shifted [DEPTH];
  logic [W-1:0]  mem_nxt [DEPTH];
  logic [CW-1:0] cnt, post, cnt_nxt;
  logic          do_pop, do_push, full_after;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wdata;

  assign data_avail = cnt != '0;
  assign q_full     = cnt == CW'(DEPTH);
  assign rx_accept  = rx_en && !q_full;
  assign rd_data    = data_avail ? mem[0] : '0;

  assign do_pop     = rd_pop && data_avail;
  assign do_push    = brk_evt || (rx_valid && rx_accept);
  assign wdata      = brk_evt ? '0 : rx_byte;
  assign post       = cnt - CW'(do_pop);
  assign full_after = post == CW'(DEPTH);
  assign wr_idx     = full_after ? IW'(DEPTH - 1) : post[IW-1:0];
  assign cnt_nxt    = (do_push && !full_after) ? post + CW'(1) : post;

  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign shifted[g] = do_pop ? mem[g+1] : mem[g];
    end else begin : g_last
      assign shifted[g] = do_pop ? '0 : mem[g];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      mem_nxt[i] = (do_push && wr_idx == IW'(i)) ? wdata : shifted[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      brk_flag <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= rx_flush ? '0 : cnt_nxt;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_nxt[i];
      if (brk_evt)      brk_flag <= 1'b1;
      else if (brk_clr) brk_flag <= 1'b0;
    end
  end

  p_accept_blocked_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !rx_accept);
  p_full_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> data_avail);
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !data_avail && !q_full);
  p_break_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);
  p_break_full_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && brk_evt && !rd_pop && !rx_flush |=> q_full);
  p_empty_pop_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail && !rx_valid && !brk_evt |=> !data_avail);
  p_pop_clears_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && rd_pop && !brk_evt && !rx_flush |=> !q_full);
endmodule

// File: tb/rx_hold_fifo_bench.sv
module rx_hold_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, rx_flush = 0, rx_valid = 0, brk_evt = 0, brk_clr = 0, rd_pop = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] rd_data;
  logic data_avail, q_full, rx_accept, brk_flag;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  rx_hold_fifo u_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_flush(rx_flush),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .brk_evt(brk_evt), .brk_clr(brk_clr),
    .rd_pop(rd_pop), .rd_data(rd_data), .data_avail(data_avail), .q_full(q_full),
    .rx_accept(rx_accept), .brk_flag(brk_flag));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic pv, logic [7:0] pd, logic pp, logic br, logic bc, logic fl);
    @(negedge clk);
    rx_valid = pv; rx_byte = pd; rd_pop = pp; brk_evt = br; brk_clr = bc; rx_flush = fl;
    @(posedge clk); #1;
    rx_valid = 0; rd_pop = 0; brk_evt = 0; brk_clr = 0; rx_flush = 0;
  endtask

  task automatic push(logic [7:0] d); step(1, d, 0, 0, 0, 0); endtask

  task automatic pop_exp(string tag, logic [7:0] exp);
    chk(tag, rd_data, exp);
    step(0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 avail", data_avail, 0); chk("R1 full", q_full, 0);
    chk("R1 data", rd_data, 0);     chk("R1 brk", brk_flag, 0);
  endtask

  task automatic t_order;
    rx_en = 1;
    push(8'hA1);
    chk("R2 avail after push", data_avail, 1);
    push(8'hB2); push(8'hC3);
    chk("R3 not full at 3", q_full, 0);
    pop_exp("R4 first", 8'hA1); pop_exp("R4 second", 8'hB2);
    chk("R2 avail one left", data_avail, 1);
    pop_exp("R4 third", 8'hC3);
    chk("R2 avail cleared", data_avail, 0);
  endtask

  task automatic t_full;
    rx_en = 1;
    push(8'h01); push(8'h02); push(8'h03);
    chk("R5 accept before full", rx_accept, 1);
    push(8'h04);
    chk("R3 full at 4", q_full, 1);
    chk("R5 accept low when full", rx_accept, 0);
    push(8'h55);
    chk("R5 still full", q_full, 1);
    pop_exp("R3 pop head", 8'h01);
    chk("R3 pop clears full", q_full, 0);
    pop_exp("R5 next", 8'h02); pop_exp("R5 next", 8'h03); pop_exp("R5 last not 55", 8'h04);
    chk("R5 empty after drain", data_avail, 0);
  endtask

  task automatic t_disabled;
    rx_en = 0;
    #1 chk("R5 accept low disabled", rx_accept, 0);
    push(8'h99);
    chk("R5 ignored disabled", data_avail, 0);
    rx_en = 1;
  endtask

  task automatic t_break;
    rx_en = 0;
    step(0, 0, 0, 1, 0, 0);
    chk("R6 break queued", data_avail, 1);
    chk("R6 flag set", brk_flag, 1);
    chk("R6 zero byte", rd_data, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R6 flag clr", brk_flag, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R6 set wins", brk_flag, 1);
    pop_exp("R6 first zero", 0); pop_exp("R6 second zero", 0);
    chk("R6 drained", data_avail, 0);
    step(0, 0, 0, 0, 1, 0);
    rx_en = 1;
  endtask

  task automatic t_break_full;
    rx_en = 1;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    step(0, 0, 0, 1, 0, 0);
    chk("R7 still full", q_full, 1);
    pop_exp("R7 e0", 8'h11); pop_exp("R7 e1", 8'h22); pop_exp("R7 e2", 8'h33);
    pop_exp("R7 newest replaced", 8'h00);
    chk("R7 empty", data_avail, 0);
    step(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_flush;
    rx_en = 1;
    push(8'h5A); push(8'h6B);
    step(1, 8'h7C, 0, 1, 0, 1);
    chk("R8 avail cleared", data_avail, 0);
    chk("R8 full cleared", q_full, 0);
    chk("R8 data zero", rd_data, 0);
    chk("R8 brk flag kept", brk_flag, 1);
    step(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_pop_empty;
    chk("R9 data zero empty", rd_data, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R9 still empty", data_avail, 0);
    chk("R9 not full", q_full, 0);
    push(8'h77);
    pop_exp("R9 no underflow", 8'h77);
    chk("R9 empty again", data_avail, 0);
  endtask

  task automatic t_simul;
    push(8'h01); push(8'h02);
    chk("R10 head before", rd_data, 8'h01);
    step(1, 8'h03, 1, 0, 0, 0);
    chk("R10 not full", q_full, 0);
    pop_exp("R10 order a", 8'h02);
    pop_exp("R10 order b", 8'h03);
    chk("R10 count kept", data_avail, 0);
  endtask

  initial begin
    #1; t_reset;
    #5 rst_n = 1;
    t_order; t_full; t_disabled; t_break; t_break_full; t_flush; t_pop_empty; t_simul;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule